// File: doc/BRIEF.md
# Dithered DAC Sub-Conversion Sequencer

This block drives the code input of a 10-bit DAC from a 16-bit buffered sample word. With dithering on, a sample holds a 10-bit integer code and a 4-bit fraction. The block turns each sample into a run of 16 sub-conversions, one for each periodic start event. Each sub-conversion emits either the integer code or the code plus one. The number of plus-one slots in a run equals the fraction, and a phase accumulator spreads them evenly, so the average over the run tracks the full-precision value.

The buffer moves into the active register only at a run boundary. The empty flag and the DMA request therefore appear once per 16 conversions. An adjust select chooses where the code and fraction sit in the written word. With dithering off, every start event makes one plain conversion of the integer code, and the buffer may be moved on every event. If a boundary event finds the buffer empty, the last sample is repeated and a sticky underrun flag is raised.

Top module: `dither_seq`

## Requirements
- R1: After reset, bufEmpty is 1, and dacStrobe, dmaReq and underrun are 0.
- R2: A buffer write makes bufEmpty 0 from the next cycle. bufEmpty returns to 1 in the same cycle that dmaReq pulses, which is when the buffered value moves into the active register.
- R3: With leftAdj = 0 at write time, the code is word bits [13:4] and the fraction is word bits [3:0].
- R4: With leftAdj = 1 at write time, the code is word bits [15:6] and the fraction is word bits [5:2].
- R5: Each cycle with startEvt high is followed, one cycle later, by exactly one cycle of dacStrobe, which carries that conversion's dacCode. No strobe occurs without an event.
- R6: With dithering on, sub-conversion k (k = 0..15) of a run outputs code + (floor((k+1)·f/16) − floor(k·f/16)), where f is the fraction. The plus-one count over the run therefore equals f, and f = 0 gives a flat run.
- R7: A plus-one slot on code 1023 outputs 1023 and does not wrap to 0.
- R8: With dithering on, a transfer (dmaReq pulse with the new code) happens only on the first event of a run, that is, once every 16 events. A value written in the middle of a run waits for the next boundary.
- R9: A boundary event with the buffer empty repeats the last active sample, gives no dmaReq, and sets underrun. A later buffer write clears underrun.
- R10: With dithering off, each event outputs the plain integer code with no plus-one. If the buffer is full, each event also transfers it and pulses dmaReq.
- R11: Turning dithering off resets the sub-conversion count and the phase, so the first event after dithering is turned back on is a run boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Buffer write strobe |
| wrData | input | 16 | Written sample word |
| leftAdj | input | 1 | Bit placement select, sampled with the write |
| ditherEn | input | 1 | Dithering enable |
| startEvt | input | 1 | Periodic start-conversion event |
| dacCode | output | 10 | Code for the DAC |
| dacStrobe | output | 1 | dacCode valid, one cycle per conversion |
| bufEmpty | output | 1 | Buffer can take a new sample |
| dmaReq | output | 1 | One-cycle refill request per transfer |
| underrun | output | 1 | Sticky: a boundary event found the buffer empty |

## Verification
The bench builds the block with its default widths: a 10-bit code and a 4-bit fraction, which gives runs of 16 events and a 16-bit word. At these widths the bench can cover both bit placements, fractions of 0, 4, 8, 7 and 15 checked slot by slot, saturation at code 1023, and the full 16-event spacing between refill requests. Mid-run writes, underrun repetition and the counter reset on a dither toggle are also reachable at these widths.

// File: rtl/dither_seq_pkg.sv
package dither_seq_pkg;
  typedef struct packed {
    logic load;     // capture a bus write into the buffer
    logic xfer;     // move buffer into active register
    logic conv;     // perform a conversion this cycle
    logic dith;     // dithering active
    logic restart;  // phase starts from zero for this conversion
  } seq_strobe_t;
endpackage

// File: rtl/dither_seq_ctrl.sv
module dither_seq_ctrl
  import dither_seq_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        ditherEn,
  input  logic        startEvt,
  output seq_strobe_t strobes,
  output logic        bufEmpty,
  output logic        dmaReq,
  output logic        underrun
);
  logic              bufFull;
  logic [FRAC_W-1:0] subCnt;
  logic              atBoundary;
  logic              doXfer;

  assign atBoundary = !ditherEn || (subCnt == '0);
  assign doXfer     = startEvt && atBoundary && bufFull;

  always_comb begin
    strobes.load    = wrEn;
    strobes.xfer    = doXfer;
    strobes.conv    = startEvt;
    strobes.dith    = ditherEn;
    strobes.restart = doXfer || !ditherEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufFull  <= 1'b0;
      subCnt   <= '0;
      dmaReq   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (wrEn) bufFull <= 1'b1;
      else if (doXfer) bufFull <= 1'b0;

      if (!ditherEn) subCnt <= '0;
      else if (startEvt) subCnt <= subCnt + 1'b1;

      dmaReq <= doXfer;

      if (wrEn) underrun <= 1'b0;
      else if (startEvt && atBoundary && !bufFull) underrun <= 1'b1;
    end
  end

  assign bufEmpty = !bufFull;
endmodule

// File: rtl/dither_seq_dp.sv
module dither_seq_dp
  import dither_seq_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int FRAC_W = 4,
  parameter int WORD_W = CODE_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic              leftAdj,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacStrobe
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam int RJ_TOP = CODE_W + FRAC_W - 1;
  localparam int LJ_FRAC_TOP = WORD_W - 1 - CODE_W;

  logic [CODE_W-1:0] bufCode, actCode, effCode, nextCode;
  logic [FRAC_W-1:0] bufFrac, actFrac, effFrac, phase, phaseIn;
  logic [FRAC_W:0]   phaseSum;
  logic [CODE_W-1:0] inCode;
  logic [FRAC_W-1:0] inFrac;
  logic              plusOne;

  always_comb begin
    if (leftAdj) begin
      inCode = wrData[WORD_W-1 -: CODE_W];
      inFrac = wrData[LJ_FRAC_TOP -: FRAC_W];
    end else begin
      inCode = wrData[RJ_TOP -: CODE_W];
      inFrac = wrData[FRAC_W-1:0];
    end
  end

  always_comb begin
    effCode  = strobes.xfer ? bufCode : actCode;
    effFrac  = strobes.xfer ? bufFrac : actFrac;
    phaseIn  = strobes.restart ? '0 : phase;
    phaseSum = {1'b0, phaseIn} + {1'b0, (strobes.dith ? effFrac : '0)};
    plusOne  = phaseSum[FRAC_W];
    nextCode = (plusOne && effCode != CODE_MAX) ? effCode + 1'b1 : effCode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufCode   <= '0;
      bufFrac   <= '0;
      actCode   <= '0;
      actFrac   <= '0;
      phase     <= '0;
      dacCode   <= '0;
      dacStrobe <= 1'b0;
    end else begin
      if (strobes.load) begin
        bufCode <= inCode;
        bufFrac <= inFrac;
      end
      if (strobes.xfer) begin
        actCode <= bufCode;
        actFrac <= bufFrac;
      end
      if (!strobes.dith) phase <= '0;
      else if (strobes.conv) phase <= phaseSum[FRAC_W-1:0];
      dacStrobe <= strobes.conv;
      if (strobes.conv) dacCode <= nextCode;
    end
  end
endmodule

// File: rtl/dither_seq.sv
module dither_seq
  import dither_seq_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int FRAC_W = 4,
  localparam int WORD_W = CODE_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              leftAdj,
  input  logic              ditherEn,
  input  logic              startEvt,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacStrobe,
  output logic              bufEmpty,
  output logic              dmaReq,
  output logic              underrun
);
  seq_strobe_t strobes;

  dither_seq_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .ditherEn(ditherEn),
    .startEvt(startEvt), .strobes(strobes), .bufEmpty(bufEmpty),
    .dmaReq(dmaReq), .underrun(underrun)
  );

  dither_seq_dp #(.CODE_W(CODE_W), .FRAC_W(FRAC_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .leftAdj(leftAdj), .dacCode(dacCode), .dacStrobe(dacStrobe)
  );
endmodule

// File: rtl/dither_seq_chk.sv
module dither_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wrEn,
  input logic ditherEn,
  input logic startEvt,
  input logic dacStrobe,
  input logic bufEmpty,
  input logic dmaReq,
  input logic underrun
);
  assert_strobe_follows_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    startEvt |=> dacStrobe);
  assert_no_spurious_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !startEvt |=> !dacStrobe);
  assert_write_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !bufEmpty);
  assert_dma_sets_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dmaReq && !$past(wrEn)) |-> bufEmpty);
  assert_dma_on_conversion_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmaReq |-> dacStrobe);
  assert_underrun_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> dacStrobe);
  assert_plain_transfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (startEvt && !ditherEn && !bufEmpty && !wrEn) |=> dmaReq);
endmodule

bind dither_seq dither_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .ditherEn(ditherEn),
  .startEvt(startEvt), .dacStrobe(dacStrobe), .bufEmpty(bufEmpty),
  .dmaReq(dmaReq), .underrun(underrun)
);

// File: tb/tb_dither_seq.sv
module tb_dither_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        leftAdj = 1'b0;
  logic        ditherEn = 1'b0;
  logic        startEvt = 1'b0;
  logic [9:0]  dacCode;
  logic        dacStrobe, bufEmpty, dmaReq, underrun;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dither_seq dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData), .leftAdj(leftAdj),
    .ditherEn(ditherEn), .startEvt(startEvt), .dacCode(dacCode),
    .dacStrobe(dacStrobe), .bufEmpty(bufEmpty), .dmaReq(dmaReq), .underrun(underrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int plusAt(input int f, input int k);
    return ((k + 1) * f) / 16 - (k * f) / 16;
  endfunction

  function automatic int expCode(input int code, input int f, input int k);
    int v = code + plusAt(f, k);
    return (v > 1023) ? 1023 : v;
  endfunction

  // all tasks start and end at a negedge
  task automatic writeBuf(input logic [15:0] w, input logic adj);
    wrEn = 1'b1; wrData = w; leftAdj = adj;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic fire(output int code, output int strb, output int dma,
                      output int emp, output int und);
    startEvt = 1'b1;
    @(negedge clk);
    startEvt = 1'b0;
    code = dacCode; strb = dacStrobe; dma = dmaReq; emp = bufEmpty; und = underrun;
  endtask

  // one dithered run of 16, starting at a boundary with buffer written
  task automatic checkRun(input string tag, input int code, input int f, input int firstDma);
    int c, s, d, e, u, plusSum;
    plusSum = 0;
    for (int k = 0; k < 16; k++) begin
      fire(c, s, d, e, u);
      check({tag, " R5 strobe"}, s, 1);
      check({tag, " R6 code"}, c, expCode(code, f, k));
      check({tag, " R8 dma"}, d, (k == 0) ? firstDma : 0);
      if (c > code) plusSum++;
    end
    if (code < 1023) check({tag, " R6 plus count"}, plusSum, f);
  endtask

  task automatic testReset();
    check("R1 empty", bufEmpty, 1);
    check("R1 strobe", dacStrobe, 0);
    check("R1 dma", dmaReq, 0);
    check("R1 underrun", underrun, 0);
  endtask

  task automatic testPlain();
    int c, s, d, e, u;
    ditherEn = 1'b0;
    writeBuf(16'h1234, 1'b0);
    check("R2 write clears empty", bufEmpty, 0);
    fire(c, s, d, e, u);
    check("R10 R3 plain code", c, 10'h123);
    check("R10 dma", d, 1);
    check("R2 empty on transfer", e, 1);
    @(negedge clk);
    check("R5 strobe one cycle", dacStrobe, 0);
    fire(c, s, d, e, u);
    check("R10 repeat code", c, 10'h123);
    check("R9 no dma on underrun", d, 0);
    check("R9 underrun set", u, 1);
    writeBuf(16'h0ABF, 1'b0);
    check("R9 write clears underrun", underrun, 0);
    fire(c, s, d, e, u);
    check("R10 no plus one", c, 10'h0AB);
  endtask

  task automatic testDither();
    ditherEn = 1'b1;
    @(negedge clk);
    writeBuf(16'h1210, 1'b1);   // left adjust: code 0x48, frac 4
    checkRun("R4 f4", 10'h048, 4, 1);
    writeBuf(16'h12E0, 1'b1);   // code 0x4B, frac 8
    checkRun("R4 f8", 10'h04B, 8, 1);
    writeBuf(16'h0ABF, 1'b0);   // right: code 0xAB, frac 15
    checkRun("R3 f15", 10'h0AB, 15, 1);
    writeBuf(16'h0550, 1'b0);   // code 0x55, frac 0
    checkRun("R3 f0", 10'h055, 0, 1);
  endtask

  task automatic testSaturate();
    writeBuf(16'h3FF7, 1'b0);   // code 1023, frac 7
    checkRun("R7 sat", 1023, 7, 1);
  endtask

  task automatic testMidWrite();
    int c, s, d, e, u;
    writeBuf(16'h0123, 1'b0);   // code 0x12, frac 3
    for (int k = 0; k < 4; k++) begin
      fire(c, s, d, e, u);
      check("R8 first part", c, expCode(10'h012, 3, k));
    end
    writeBuf(16'h0A49, 1'b0);   // code 0xA4, frac 9
    check("R8 buffer held", bufEmpty, 0);
    for (int k = 4; k < 16; k++) begin
      fire(c, s, d, e, u);
      check("R8 old value kept", c, expCode(10'h012, 3, k));
      check("R8 no early dma", d, 0);
    end
    checkRun("R8 next run", 10'h0A4, 9, 1);
  endtask

  task automatic testUnderrun();
    checkRun("R9 repeat", 10'h0A4, 9, 0);
    check("R9 underrun sticky", underrun, 1);
  endtask

  task automatic testToggle();
    int c, s, d, e, u;
    writeBuf(16'h0884, 1'b0);   // code 0x88, frac 4
    for (int k = 0; k < 3; k++) fire(c, s, d, e, u);
    ditherEn = 1'b0;
    @(negedge clk);
    ditherEn = 1'b1;
    writeBuf(16'h0316, 1'b0);   // code 0x31, frac 6
    checkRun("R11 restart", 10'h031, 6, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPlain();
    testDither();
    testSaturate();
    testMidWrite();
    testUnderrun();
    testToggle();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule